// File: doc/BRIEF.md
# Infrared Pulse Modulator (4PPM / RZI)

This block turns a stream of transmit symbols into the single pulse line that drives an external infrared transceiver. In fast mode each accepted symbol is a dibit that picks one of four chip slots inside the symbol; the line is high for exactly that chip. In slow and medium modes each accepted symbol carries one bit: a zero bit raises a short pulse at the start of the bit cell, a one bit leaves the line low.

The block keeps no notion of time of its own. A symbol strobe from an external rate generator marks every symbol (or bit-cell) boundary, and a pulse-width strobe marks every chip boundary in fast mode and the end of the pulse in slow and medium modes. The generator therefore sets the 3/16-cell pulse of slow mode, the 1/4-cell pulse of medium mode and the 125 ns chip of fast mode. Symbols enter on a valid/ready port: ready is raised only in a cycle that carries the symbol strobe, so the source must hold valid and data steady until that cycle; a symbol is taken when valid and ready are both high. Between strobes the port applies back-pressure by holding ready low.

Top module: `irtx_modulator`

## Requirements
- R1: While reset is asserted, tx_out is low and in_ready is low even if sym_stb is high.
- R2: in_ready is high exactly in the cycles where sym_stb is high (out of reset), whatever in_valid is; a symbol is taken only in a cycle where in_valid and in_ready are both high.
- R3: In fast mode (mode_fast = 1) a taken symbol with value d on in_data[1:0] drives the line high for chip d only, chip 0 starting at the symbol strobe and each later pw_stb starting the next chip; a strobe in cycle t first shows on tx_out in cycle t+2.
- R4: In slow/medium mode (mode_fast = 0) a taken symbol with in_data[0] = 0 raises the line at the symbol strobe; in_data[0] = 1 leaves it low; in_data[1] has no effect.
- R5: In slow/medium mode the pulse ends at the first pw_stb after the symbol strobe, so a pw_stb k cycles after the symbol strobe gives a pulse k cycles long.
- R6: When sym_stb and pw_stb fall in the same cycle the symbol strobe wins and that pw_stb is ignored by the symbol it starts.
- R7: A symbol strobe with in_valid low makes that cell idle: the line goes low and stays low until a symbol is taken.
- R8: The mode is sampled when a symbol is taken; changing mode_fast during a symbol does not alter that symbol's waveform.
- R9: In fast mode the chip-3 pulse ends at the next strobe of either kind; further pw_stb pulses within the symbol keep the line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fast | input | 1 | 1 = pulse-position coding, 0 = return-to-zero-inverted coding |
| sym_stb | input | 1 | Symbol / bit-cell boundary strobe |
| pw_stb | input | 1 | Chip boundary (fast) or pulse end (slow/medium) strobe |
| in_valid | input | 1 | Transmit symbol valid |
| in_ready | output | 1 | Symbol accepted this cycle when valid |
| in_data | input | 2 | Dibit (fast) or bit in bit 0 (slow/medium) |
| tx_out | output | 1 | Registered pulse line to the transceiver |

## Verification
The two functions that can land in one cycle are the start of a new symbol and the pulse-width boundary of the previous chip or pulse. The bench provokes this by issuing pw_stb on the very cycle of each symbol strobe, for all four dibits and for a zero bit, and judges it by comparing the recorded tx_out patterns against the patterns of the same symbols sent without the coinciding strobe, which must be identical.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  typedef enum logic {
    CODE_RZI = 1'b0,
    CODE_PPM = 1'b1
  } irtx_code_e;
endpackage

// File: rtl/irtx_accept_gate.sv
module irtx_accept_gate
  import irtx_pkg::*;
(
  input  logic rst_n,
  input  logic sym_stb,
  input  logic in_valid,
  input  logic mode_fast,
  output logic in_ready,
  output logic take_ppm,
  output logic take_rzi,
  output logic halt_ppm,
  output logic halt_rzi
);
  irtx_code_e code;
  logic       accept;

  always_comb begin
    code     = irtx_code_e'(mode_fast);
    in_ready = rst_n & sym_stb;
    accept   = in_ready & in_valid;
    take_ppm = accept & (code == CODE_PPM);
    take_rzi = accept & (code == CODE_RZI);
    // any boundary that does not start this coder's own symbol stops it
    halt_ppm = sym_stb & ~take_ppm;
    halt_rzi = sym_stb & ~take_rzi;
  end
endmodule

// File: rtl/irtx_ppm_coder.sv
module irtx_ppm_coder #(
  parameter int unsigned CHIPS = 4,
  localparam int unsigned SYM_W = $clog2(CHIPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             halt,
  input  logic             pw_stb,
  input  logic [SYM_W-1:0] dibit,
  output logic             pulse
);
  localparam logic [SYM_W-1:0] LAST = SYM_W'(CHIPS - 1);

  logic [SYM_W-1:0] slot_q, pos_q, pos_nx;
  logic             run_q, pulse_q;

  always_comb pos_nx = pos_q + SYM_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q  <= '0;
      pos_q   <= '0;
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (take) begin
      slot_q  <= dibit;
      pos_q   <= '0;
      run_q   <= 1'b1;
      pulse_q <= (dibit == '0);
    end else if (halt) begin
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (pw_stb && run_q) begin
      if (pos_q == LAST) begin
        run_q   <= 1'b0;
        pulse_q <= 1'b0;
      end else begin
        pos_q   <= pos_nx;
        pulse_q <= (pos_nx == slot_q);
      end
    end
  end

  assign pulse = pulse_q;

  // R3: the line is only ever high in the chip named by the symbol
  a_r3_pulse_on_own_chip: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (run_q && pos_q == slot_q));

  // R6: a chip strobe on the start cycle does not advance the chip
  a_r6_tie_restarts_chip: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pw_stb) |=> (pos_q == '0 && run_q));

  // R9: a strobe past the last chip closes the symbol
  a_r9_last_chip_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && pos_q == LAST && pw_stb && !take && !halt) |=> (!pulse_q && !run_q));
endmodule

// File: rtl/irtx_rzi_coder.sv
module irtx_rzi_coder (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic halt,
  input  logic pw_stb,
  input  logic bit_in,
  output logic pulse
);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              pulse_q <= 1'b0;
    else if (take)           pulse_q <= ~bit_in;
    else if (halt || pw_stb) pulse_q <= 1'b0;
  end

  assign pulse = pulse_q;

  // R4: a zero bit raises the line, a one bit keeps it low
  a_r4_zero_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bit_in) |=> pulse_q);
  a_r4_one_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bit_in) |=> !pulse_q);

  // R5: the width strobe ends the pulse
  a_r5_width_strobe_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_stb && !take) |=> !pulse_q);
endmodule

// File: rtl/irtx_modulator.sv
module irtx_modulator #(
  parameter int unsigned PPM_CHIPS = 4,
  parameter bit          OUT_REG   = 1'b1,
  localparam int unsigned SYM_W    = $clog2(PPM_CHIPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_fast,
  input  logic             sym_stb,
  input  logic             pw_stb,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  output logic             tx_out
);
  logic take_ppm, take_rzi, halt_ppm, halt_rzi;
  logic ppm_pulse, rzi_pulse, line_nx;

  irtx_accept_gate u_gate (
    .rst_n    (rst_n),
    .sym_stb  (sym_stb),
    .in_valid (in_valid),
    .mode_fast(mode_fast),
    .in_ready (in_ready),
    .take_ppm (take_ppm),
    .take_rzi (take_rzi),
    .halt_ppm (halt_ppm),
    .halt_rzi (halt_rzi)
  );

  irtx_ppm_coder #(.CHIPS(PPM_CHIPS)) u_ppm (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take_ppm),
    .halt  (halt_ppm),
    .pw_stb(pw_stb),
    .dibit (in_data),
    .pulse (ppm_pulse)
  );

  irtx_rzi_coder u_rzi (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take_rzi),
    .halt  (halt_rzi),
    .pw_stb(pw_stb),
    .bit_in(in_data[0]),
    .pulse (rzi_pulse)
  );

  always_comb line_nx = ppm_pulse | rzi_pulse;

  generate
    if (OUT_REG) begin : g_out_reg
      logic tx_q;
      always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= 1'b0;
        else        tx_q <= line_nx;
      end
      assign tx_out = tx_q;

      // R7: an idle cell pulls the line low two edges after its strobe
      a_r7_idle_cell_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && !in_valid) |=> ##1 !tx_out);
    end else begin : g_out_comb
      assign tx_out = line_nx;
    end
  endgenerate

  // R8: one coding owns the line at a time
  a_r8_coders_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ppm_pulse && rzi_pulse));
endmodule

// File: tb/irtx_modulator_test.sv
module irtx_modulator_test;
  localparam int CLK_PERIOD = 10;
  localparam int HIST = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_fast = 1'b0;
  logic       sym_stb = 1'b0;
  logic       pw_stb = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_data = 2'b00;
  logic       in_ready, tx_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic hist [HIST];

  irtx_modulator uut (
    .clk(clk), .rst_n(rst_n), .mode_fast(mode_fast), .sym_stb(sym_stb),
    .pw_stb(pw_stb), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tx_out(tx_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (cyc < HIST) hist[cyc] <= tx_out;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; returns in_ready seen during it
  task automatic step(input logic s, input logic p, input logic v,
                      input logic [1:0] d, input logic m, output logic rdy);
    sym_stb = s; pw_stb = p; in_valid = v; in_data = d; mode_fast = m;
    #1 rdy = in_ready;
    @(negedge clk);
  endtask

  // one symbol of 'period' cycles, pw strobe every 'gap' cycles
  task automatic symbol(input logic v, input logic [1:0] d, input int period,
                        input int gap, input logic pw0, input logic m0,
                        input logic m1, output int s, output logic rdy0);
    logic r;
    s = cyc;
    rdy0 = 1'b0;
    for (int i = 0; i < period; i++) begin
      step(i == 0, (i == 0) ? pw0 : (i % gap == 0), (i == 0) ? v : 1'b0,
           (i == 0) ? d : 2'b00, (i == 0) ? m0 : m1, r);
      if (i == 0) rdy0 = r;
    end
  endtask

  task automatic flush();
    logic r;
    step(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, r);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, r);
  endtask

  function automatic logic [15:0] mask_of(input int s, input int n);
    logic [15:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = hist[s + 2 + i];
    return m;
  endfunction

  task automatic t_reset();
    sym_stb = 1'b1; in_valid = 1'b1;
    #1;
    chk(tx_out == 1'b0, "R1 tx low in reset", int'(tx_out), 0);
    chk(in_ready == 1'b0, "R1 ready low in reset", int'(in_ready), 0);
    sym_stb = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_ppm(input logic tie, input string req);
    int s [4];
    logic r;
    for (int d = 0; d < 4; d++) symbol(1'b1, 2'(d), 8, 2, tie, 1'b1, 1'b1, s[d], r);
    flush();
    for (int d = 0; d < 4; d++)
      chk(mask_of(s[d], 8) == (16'h3 << (2 * d)), req,
          int'(mask_of(s[d], 8)), int'(16'h3 << (2 * d)));
  endtask

  task automatic t_rzi();
    int s0, s1, s2, s3, s4;
    logic r;
    symbol(1'b1, 2'b00, 16, 3, 1'b0, 1'b0, 1'b0, s0, r);  // slow, zero
    symbol(1'b1, 2'b01, 16, 3, 1'b0, 1'b0, 1'b0, s1, r);  // slow, one
    symbol(1'b1, 2'b10, 16, 3, 1'b0, 1'b0, 1'b0, s2, r);  // bit1 ignored
    symbol(1'b1, 2'b00, 8, 2, 1'b0, 1'b0, 1'b0, s3, r);   // medium, zero
    symbol(1'b1, 2'b00, 16, 3, 1'b1, 1'b0, 1'b0, s4, r);  // tie on start
    flush();
    chk(mask_of(s0, 16) == 16'h0007, "R5 slow zero width", int'(mask_of(s0, 16)), 'h7);
    chk(mask_of(s1, 16) == 16'h0000, "R4 one stays low", int'(mask_of(s1, 16)), 0);
    chk(mask_of(s2, 16) == 16'h0007, "R4 bit1 ignored", int'(mask_of(s2, 16)), 'h7);
    chk(mask_of(s3, 8) == 16'h0003, "R5 medium zero width", int'(mask_of(s3, 8)), 'h3);
    chk(mask_of(s4, 16) == 16'h0007, "R6 rzi tie", int'(mask_of(s4, 16)), 'h7);
  endtask

  task automatic t_idle_and_last();
    int s0, s1, s2, s3;
    logic r;
    symbol(1'b1, 2'b11, 10, 2, 1'b0, 1'b1, 1'b1, s0, r);  // pw at 8 past chip 3
    symbol(1'b0, 2'b00, 8, 2, 1'b1, 1'b1, 1'b1, s1, r);   // idle fast
    symbol(1'b1, 2'b00, 8, 2, 1'b0, 1'b0, 1'b0, s2, r);
    symbol(1'b0, 2'b00, 8, 2, 1'b0, 1'b0, 1'b0, s3, r);   // idle slow
    flush();
    chk(mask_of(s0, 10) == 16'h00C0, "R9 chip3 closed by pw", int'(mask_of(s0, 10)), 'hC0);
    chk(mask_of(s1, 8) == 16'h0000, "R7 idle fast low", int'(mask_of(s1, 8)), 0);
    chk(mask_of(s2, 8) == 16'h0003, "R5 pulse before idle", int'(mask_of(s2, 8)), 'h3);
    chk(mask_of(s3, 8) == 16'h0000, "R7 idle slow low", int'(mask_of(s3, 8)), 0);
  endtask

  task automatic t_mode_latch();
    int s0, s1;
    logic r;
    symbol(1'b1, 2'b10, 8, 2, 1'b0, 1'b1, 1'b0, s0, r);
    symbol(1'b1, 2'b00, 16, 3, 1'b0, 1'b0, 1'b1, s1, r);
    flush();
    chk(mask_of(s0, 8) == 16'h0030, "R8 fast held", int'(mask_of(s0, 8)), 'h30);
    chk(mask_of(s1, 16) == 16'h0007, "R8 slow held", int'(mask_of(s1, 16)), 'h7);
  endtask

  task automatic t_backpressure();
    int s0, s1;
    logic r;
    s0 = cyc;
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 1'b1, 2'b01, 1'b1, r);
      chk(r == 1'b0, "R2 ready low off strobe", int'(r), 0);
    end
    symbol(1'b1, 2'b01, 8, 2, 1'b0, 1'b1, 1'b1, s1, r);
    chk(r == 1'b1, "R2 ready on strobe", int'(r), 1);
    symbol(1'b0, 2'b00, 8, 2, 1'b0, 1'b1, 1'b1, s0, r);
    chk(r == 1'b1, "R2 ready without valid", int'(r), 1);
    flush();
    chk(mask_of(s1 - 3, 3) == 16'h0000, "R2 no take while waiting",
        int'(mask_of(s1 - 3, 3)), 0);
    chk(mask_of(s1, 8) == 16'h000C, "R3 dibit 01 after wait", int'(mask_of(s1, 8)), 'hC);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic r;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, r);
    chk(tx_out == 1'b0, "R1 low after reset", int'(tx_out), 0);
    t_ppm(1'b0, "R3 ppm dibit chip");
    t_ppm(1'b1, "R6 ppm tie");
    t_rzi();
    t_idle_and_last();
    t_mode_latch();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule